// File: doc/BRIEF.md
# Attach Detection Probe and Sense Controller

This block is the digital half of a USB On-The-Go attach detector. It runs from a slow 32.768-kHz clock and steers three analog helpers: a current sink and a current source on the bus, and a probe comparator. It also watches a second, sense comparator. A 2-bit mode input picks the job. In sensing mode the block expects a steady stream of rising edges from the sense comparator. It flags an interrupt when the gap since the last edge reaches a programmed timeout.

In probing mode the block runs a fixed sequence. It discharges the bus with the sink for a parameterised number of cycles. It then switches to the source and counts cycles until the probe comparator trips or the count saturates at its maximum. The final count is compared with a software low limit and a software high limit, and the block raises an interrupt when the count falls outside that window. The interrupt is sticky and is cleared by a write-one-to-clear pulse. The measured count stays on the output until the next probe begins.

Top module: `attach_detect_ctrl`

## Requirements
- R1: Mode code 00 and mode code 11 are both disabled. In these modes every enable output stays low, no interrupt is raised, and a start pulse is ignored. Code 01 selects sensing and drives the sense comparator enable high. Code 10 selects probing.
- R2: In sensing mode with timeout T (T >= 1), if no rising edge has been detected, the interrupt becomes visible after exactly T clock edges from entering the mode. It is not visible after T-1 edges.
- R3: Every rising edge of the sense comparator, detected through a two-flop synchronizer, reloads the sensing timer. With timeout T, edges every P cycles raise no interrupt when P <= T. They raise one when P = T+1.
- R4: A probe start clears the count and enables the probe comparator. It drives the sink enable for exactly SINK_CYCLES cycles, and the source enable rises on the same edge that the sink enable falls.
- R5: While the source is on, the count increments once per cycle. The probe comparator passes through a two-flop synchronizer. If the comparator goes high in source cycle k (where k = 0 is the first cycle), the final count is k+2.
- R6: If the probe comparator never trips, the count stops at 255. The source and the probe comparator enables then drop.
- R7: At the end of a probe, the interrupt is set exactly when the final count is below the low limit or above the high limit. Counts equal to either limit do not set it.
- R8: The interrupt stays set until an irq_clr pulse clears it.
- R9: A probe starts on entry into mode 10, or on a start pulse while in mode 10 and idle. The count keeps its value through other modes and ignored start pulses, until the next probe starts.
- R10: Leaving mode 10 in the middle of a sequence drops all probe enables in that cycle and returns the block to idle. Re-entering mode 10 starts a fresh probe.
- R11: The sink enable and the source enable are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768-kHz operating clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 off, 01 sense, 10 probe, 11 off |
| probe_start | input | 1 | Start pulse for a probe while in mode 10 |
| lim_low | input | CNT_W | Lower bound of the accepted count window |
| lim_high | input | CNT_W | Upper bound of the accepted count window |
| sense_tmo | input | TMO_W | Sensing timeout in cycles (nonzero) |
| cmp_sense | input | 1 | Sense comparator output (asynchronous) |
| cmp_probe | input | 1 | Probe comparator output (asynchronous) |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| sink_en | output | 1 | Current sink enable |
| src_en | output | 1 | Current source enable |
| cmp_probe_en | output | 1 | Probe comparator enable |
| cmp_sense_en | output | 1 | Sense comparator enable |
| probe_count | output | CNT_W | Last measured charge count |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench sweeps the sensing timeout over small values and checks the exact edge on which the interrupt appears. A timer that is off by one would flag one cycle early or late. It then walks the edge period across the timeout boundary, which exposes a design that does not reload on edges or that lets the timeout win over a coincident edge. On the probe side, the trip point is swept so that final counts land on both sides of each limit. A window check built with inclusive or swapped comparisons would flag the wrong counts. A separate case lets the count run to saturation, where a counter that wraps would report a small count. Mid-sequence aborts, start pulses in the wrong mode, and the sink duration are also checked. These catch enables that linger after the mode changes, starts that should be ignored, and a sink phase of the wrong length.

// File: rtl/attach_detect_ctrl.sv
module attach_detect_ctrl #(
  parameter int SINK_CYCLES = 8,
  parameter int CNT_W       = 8,
  parameter int TMO_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             probe_start,
  input  logic [CNT_W-1:0] lim_low,
  input  logic [CNT_W-1:0] lim_high,
  input  logic [TMO_W-1:0] sense_tmo,
  input  logic             cmp_sense,
  input  logic             cmp_probe,
  input  logic             irq_clr,
  output logic             sink_en,
  output logic             src_en,
  output logic             cmp_probe_en,
  output logic             cmp_sense_en,
  output logic [CNT_W-1:0] probe_count,
  output logic             irq
);

  localparam int SK_W = $clog2(SINK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [TMO_W-1:0] TMO_ONE  = 1;
  localparam logic [SK_W-1:0]  SINK_END = SK_W'(SINK_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SINK, ST_CHARGE} st_t;

  st_t              st;
  logic [1:0]       mode_q;
  logic [2:0]       sns_sync;
  logic [1:0]       prb_sync;
  logic [TMO_W-1:0] tmr;
  logic [SK_W-1:0]  stmr;
  logic [CNT_W-1:0] cnt;

  wire sense_mode = (mode == 2'b01);
  wire probe_mode = (mode == 2'b10);
  wire sns_edge   = sns_sync[1] & ~sns_sync[2];
  wire tmo_hit    = sense_mode && !sns_edge && (tmr == sense_tmo - TMO_ONE);
  wire start      = probe_mode && (st == ST_IDLE) && (probe_start || mode_q != 2'b10);
  wire stop       = (st == ST_CHARGE) && (prb_sync[1] || cnt == CNT_MAX);
  wire out_win    = (cnt < lim_low) || (cnt > lim_high);
  wire irq_set    = tmo_hit || (probe_mode && stop && out_win);

  assign sink_en      = probe_mode && (st == ST_SINK);
  assign src_en       = probe_mode && (st == ST_CHARGE);
  assign cmp_probe_en = probe_mode && (st != ST_IDLE);
  assign cmp_sense_en = sense_mode;
  assign probe_count  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 2'b00;
      sns_sync <= '0;
      prb_sync <= '0;
    end else begin
      mode_q   <= mode;
      sns_sync <= {sns_sync[1:0], cmp_sense};
      prb_sync <= {prb_sync[0], cmp_probe};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tmr <= '0;
    else if (!sense_mode || sns_edge || tmo_hit)
      tmr <= '0;
    else
      tmr <= tmr + TMO_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      stmr <= '0;
      cnt  <= '0;
    end else if (!probe_mode) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_SINK;
          stmr <= '0;
          cnt  <= '0;
        end
        ST_SINK: begin
          if (stmr == SINK_END) st <= ST_CHARGE;
          else                  stmr <= stmr + 1'b1;
        end
        ST_CHARGE: begin
          if (stop) st  <= ST_IDLE;
          else      cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

endmodule

module attach_detect_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             sink_en,
  input logic             src_en,
  input logic             cmp_probe_en,
  input logic [CNT_W-1:0] probe_count,
  input logic             irq,
  input logic             irq_clr
);

  p_sink_src_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sink_en && src_en));

  p_sink_to_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sink_en) && mode == 2'b10) |-> (src_en && cmp_probe_en));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(src_en) && !$rose(sink_en)) |-> $stable(probe_count));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_irq_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(mode) == 2'b01 || $past(src_en)));

endmodule

bind attach_detect_ctrl attach_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sink_en(sink_en), .src_en(src_en),
  .cmp_probe_en(cmp_probe_en), .probe_count(probe_count), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/attach_detect_ctrl_bench.sv
module attach_detect_ctrl_bench;
  localparam int SINK = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       probe_start = 1'b0;
  logic [7:0] lim_low = 8'd20, lim_high = 8'd40, sense_tmo = 8'd4;
  logic       cmp_sense = 1'b0, cmp_probe = 1'b0, irq_clr = 1'b0;
  logic       sink_en, src_en, cmp_probe_en, cmp_sense_en, irq;
  logic [7:0] probe_count;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  attach_detect_ctrl #(.SINK_CYCLES(SINK), .CNT_W(8), .TMO_W(8)) u_attach_detect_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .probe_start(probe_start),
    .lim_low(lim_low), .lim_high(lim_high), .sense_tmo(sense_tmo),
    .cmp_sense(cmp_sense), .cmp_probe(cmp_probe), .irq_clr(irq_clr),
    .sink_en(sink_en), .src_en(src_en), .cmp_probe_en(cmp_probe_en),
    .cmp_sense_en(cmp_sense_en), .probe_count(probe_count), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); probe_start = 1'b1;
    @(negedge clk); probe_start = 1'b0;
  endtask

  // Caller has already triggered the probe; n_trip < 0 means never trip.
  task automatic finish_probe(input int n_trip, output int sink_seen, output int cnt_out);
    sink_seen = 0;
    while (!src_en) begin
      if (sink_en) sink_seen++;
      if (sink_en && !cmp_probe_en) chk("R4 cmp enabled during sink", 0, 1);
      @(negedge clk);
    end
    if (n_trip >= 0) begin
      repeat (n_trip) @(negedge clk);
      cmp_probe = 1'b1;
    end
    while (cmp_probe_en) @(negedge clk);
    cmp_probe = 1'b0;
    cnt_out = probe_count;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sink", sink_en, 0);
    chk("R1 reset src", src_en, 0);
    chk("R1 reset cmp_probe_en", cmp_probe_en, 0);
    chk("R1 reset cmp_sense_en", cmp_sense_en, 0);
    chk("R1 reset irq", irq, 0);
    chk("R9 reset count", probe_count, 0);

    // R2: exact timeout edge for several timeouts
    for (int t = 1; t <= 6; t++) begin
      mode = 2'b00; sense_tmo = 8'(t);
      clear_irq();
      @(negedge clk); mode = 2'b01;
      repeat (t - 1) @(negedge clk);
      chk("R1 sense enable", cmp_sense_en, 1);
      if (t > 1) chk("R2 no irq at T-1", irq, 0);
      @(negedge clk);
      chk("R2 irq at T", irq, 1);
    end

    // R3: edge period sweep around timeout 4
    sense_tmo = 8'd4;
    for (int p = 2; p <= 5; p++) begin
      mode = 2'b00; cmp_sense = 1'b0;
      repeat (4) @(negedge clk);
      clear_irq();
      @(negedge clk); mode = 2'b01;
      for (int k = 0; k < 12; k++) begin
        cmp_sense = 1'b1; @(negedge clk);
        cmp_sense = 1'b0; repeat (p - 1) @(negedge clk);
      end
      chk("R3 edge reload vs period", irq, (p > 4) ? 1 : 0);
    end

    // R1: disabled codes stay quiet
    mode = 2'b00; cmp_sense = 1'b0; sense_tmo = 8'd3;
    clear_irq();
    for (int m = 0; m < 2; m++) begin
      int seen;
      seen = 0;
      @(negedge clk); mode = (m == 0) ? 2'b11 : 2'b00;
      pulse_start();
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        seen |= int'(sink_en | src_en | cmp_probe_en | cmp_sense_en);
      end
      chk("R1 disabled no enables", seen, 0);
      chk("R1 disabled no irq", irq, 0);
    end

    // R4 + R5 + R7: sweep the trip point across both limits
    lim_low = 8'd20; lim_high = 8'd40;
    for (int n = 0; n <= 60; n++) begin
      int e;
      if (n == 0) begin
        clear_irq();
        @(negedge clk); mode = 2'b10;
        @(negedge clk);
      end else begin
        clear_irq();
        pulse_start();
      end
      finish_probe(n, s, c);
      e = n + 2;
      if (n == 0 || n == 30) chk("R4 sink duration", s, SINK);
      chk("R5 measured count", c, e);
      chk("R7 window irq", irq, (e < 20 || e > 40) ? 1 : 0);
    end

    // R6: saturation
    clear_irq();
    pulse_start();
    finish_probe(-1, s, c);
    chk("R6 saturated count", c, 255);
    chk("R6 source off", src_en, 0);
    chk("R7 irq above high", irq, 1);

    // R8: sticky until cleared
    repeat (20) @(negedge clk);
    chk("R8 irq holds", irq, 1);
    clear_irq();
    chk("R8 irq cleared", irq, 0);

    // R9: count held through other modes and ignored pulses
    @(negedge clk); mode = 2'b01; sense_tmo = 8'd200;
    pulse_start();
    repeat (10) @(negedge clk);
    chk("R9 count held", probe_count, 255);
    chk("R9 no sink outside mode 10", sink_en, 0);
    mode = 2'b10;
    @(negedge clk);
    chk("R9 entry starts probe", sink_en, 1);
    chk("R9 count cleared at start", probe_count, 0);

    // R10: abort during sink, then during charge
    @(negedge clk); mode = 2'b00;
    @(negedge clk);
    chk("R10 abort in sink", int'(sink_en | src_en | cmp_probe_en), 0);
    @(negedge clk); mode = 2'b10;
    @(negedge clk);
    chk("R10 re-entry restarts", sink_en, 1);
    while (!src_en) @(negedge clk);
    repeat (5) @(negedge clk);
    mode = 2'b00;
    @(negedge clk);
    chk("R10 abort in charge", int'(sink_en | src_en | cmp_probe_en), 0);
    chk("R10 abort no irq", irq, 0);
    @(negedge clk); mode = 2'b10;
    @(negedge clk);
    chk("R10 fresh probe", sink_en, 1);
    chk("R11 sink and source apart", int'(sink_en & src_en), 0);
    finish_probe(25, s, c);
    chk("R5 count after abort", c, 27);
    chk("R7 in-window no irq", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule